// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block makes the sampling tick for a UART from a reference clock. The clock is divided by a 16-bit integer divisor and a 4-bit fraction. The divisor is loaded as two bytes. The fraction sits in the low nibble of a configuration byte. The effective divide ratio per bit is sixteen times the divisor plus the fraction. The generator gets there by stretching selected tick periods by one reference cycle. An accumulator decides which periods are stretched, so that over time the average rate is exact.

The block drives two outputs. `tick` is the oversampling strobe. `bit_tick` marks the tick that ends each bit time. A bit normally spans sixteen ticks. Two configuration bits shorten a bit to eight or four ticks, so the same divisor gives twice or four times the bit rate. A further configuration bit stops both outputs to save power.

Any register write restarts the tick counters from zero. The output stays low in the cycle after the write, so a write never produces a short tick. The three registers can be read back at any time. After reset the low divisor byte reads 1, and software can poll this value to see that the block is ready.

Top module: `frac_baud_gen`

## Requirements
- R1: During and after reset, no tick or bit tick is driven while reset is held. After reset, reads return 0x01 at address 0 (divisor low byte), 0x00 at address 1 (divisor high byte), 0x00 at address 2 (configuration), and 0x00 at address 3, which is unused.
- R2: A write stores its byte at the addressed register (0 = divisor low byte, 1 = divisor high byte, 2 = configuration). Bit 7 of the configuration register is not stored and reads as 0.
- R3: Let D be the divisor and F be configuration bits [3:0]. Count the clock edge that performs the last write as edge 0. Tick number n (n >= 1) is then high after edge n*D + floor((n-1)*F/16) and low after every other edge. This makes 16 ticks last 16*D+F cycles on average.
- R4: A divisor of zero behaves exactly like a divisor of one, and it still reads back as zero.
- R5: `bit_tick` is high together with tick number n exactly when n is a multiple of the ticks per bit. That number is 16 by default, 8 when configuration bit 4 is set, and 4 when configuration bit 5 is set. Bit 5 wins when both bits are set.
- R6: While configuration bit 6 is set, `tick` and `bit_tick` stay low.
- R7: After any register write, `tick` and `bit_tick` are low in the following cycle, and counting starts again from zero.
- R8: At the extremes of the range, a divisor of 1 with fraction 0 in quadruple mode ticks every cycle and gives a bit tick every 4 cycles. A divisor of 0xFFFF gives its first tick 65535 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 divisor low, 1 divisor high, 2 configuration) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same encoding |
| rd_data | output | 8 | Combinational read data |
| tick | output | 1 | Oversampling tick, one cycle wide |
| bit_tick | output | 1 | Tick that closes a bit time |

## Verification
The checker watches several rules on every cycle:
- the outputs are quiet after a write and while the clock is disabled;
- a bit tick only appears together with a sample tick;
- ticks are never back to back when the divisor exceeds one;
- bit ticks never come in consecutive cycles;
- a stretched period only happens with a nonzero fraction.

The exact position of each tick is left to the bench's scenarios, which compare whole tick trains with a closed-form position formula. These cover the fraction's spread of stretched periods, the ticks per bit in each rate mode, the zero-divisor case, the slowest divisor and register readback.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    REG_DIV_LO = 2'd0,
    REG_DIV_HI = 2'd1,
    REG_CFG    = 2'd2,
    REG_NONE   = 2'd3
  } fbg_reg_e;

  localparam int unsigned BASE_TICKS = 16;

  // Sample ticks per bit time: quad mode wins over double mode.
  function automatic logic [4:0] ticks_per_bit(input logic dbl, input logic quad);
    logic [4:0] base;
    base = 5'(BASE_TICKS);
    if (quad)     return base >> 2;
    else if (dbl) return base >> 1;
    else          return base;
  endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DIV_W-1:0]  div_eff,
  output logic [FRAC_W-1:0] frac,
  output logic              rate_x2,
  output logic              rate_x4,
  output logic              clk_off
);
  localparam int CFG_W = FRAC_W + 3;
  localparam logic [DATA_W-1:0] LO_RESET = DATA_W'(1);
  localparam logic [DIV_W-1:0]  DIV_ONE  = DIV_W'(1);

  logic [DATA_W-1:0] div_lo_q, div_hi_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [DIV_W-1:0]  div_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo_q <= LO_RESET;
      div_hi_q <= '0;
      cfg_q    <= '0;
    end else if (wr_en) begin
      case (fbg_reg_e'(wr_addr))
        REG_DIV_LO: div_lo_q <= wr_data;
        REG_DIV_HI: div_hi_q <= wr_data;
        REG_CFG:    cfg_q    <= wr_data[CFG_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (fbg_reg_e'(rd_addr))
      REG_DIV_LO: rd_data = div_lo_q;
      REG_DIV_HI: rd_data = div_hi_q;
      REG_CFG:    rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
      default:    rd_data = '0;
    endcase
  end

  assign div_raw = {div_hi_q, div_lo_q};
  assign div_eff = (div_raw == '0) ? DIV_ONE : div_raw;
  assign frac    = cfg_q[FRAC_W-1:0];
  assign rate_x2 = cfg_q[FRAC_W];
  assign rate_x4 = cfg_q[FRAC_W+1];
  assign clk_off = cfg_q[FRAC_W+2];

endmodule

// File: rtl/fbg_period.sv
module fbg_period #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              clk_off,
  input  logic [DIV_W-1:0]  div_eff,
  input  logic [FRAC_W-1:0] frac,
  output logic              hit,
  output logic              stretch,
  output logic              tick
);
  localparam logic [DIV_W:0]   WIDE_ONE = (DIV_W+1)'(1);
  localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);

  logic [DIV_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              stretch_q, tick_q;
  logic [DIV_W:0]    target;
  logic [FRAC_W:0]   acc_sum;

  // Period of the current interval: divisor, plus one when the last carry fired.
  assign target  = {1'b0, div_eff} - WIDE_ONE + {{DIV_W{1'b0}}, stretch_q};
  assign hit     = ({1'b0, cnt_q} == target) && !restart && !clk_off;
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (!rst_n || restart || clk_off) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
      tick_q    <= 1'b0;
    end else if (hit) begin
      cnt_q     <= '0;
      acc_q     <= acc_sum[FRAC_W-1:0];
      stretch_q <= acc_sum[FRAC_W];
      tick_q    <= 1'b1;
    end else begin
      cnt_q     <= cnt_q + CNT_ONE;
      tick_q    <= 1'b0;
    end
  end

  assign stretch = stretch_q;
  assign tick    = tick_q;

endmodule

// File: rtl/fbg_bitdiv.sv
module fbg_bitdiv #(
  parameter int SUB_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           clk_off,
  input  logic           hit,
  input  logic [SUB_W:0] tpb,
  output logic           bit_tick
);
  localparam logic [SUB_W:0]   TPB_ONE = (SUB_W+1)'(1);
  localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);

  logic [SUB_W-1:0] sub_q;
  logic             bit_q;
  logic             last;

  assign last = ({1'b0, sub_q} == (tpb - TPB_ONE));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || clk_off) begin
      sub_q <= '0;
      bit_q <= 1'b0;
    end else if (hit) begin
      sub_q <= last ? '0 : sub_q + SUB_ONE;
      bit_q <= last;
    end else begin
      bit_q <= 1'b0;
    end
  end

  assign bit_tick = bit_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick,
  output logic              bit_tick
);
  localparam int DIV_W = 2 * DATA_W;

  logic [DIV_W-1:0]  div_eff;
  logic [FRAC_W-1:0] frac;
  logic              rate_x2, rate_x4, clk_off;
  logic              tick_hit, stretch;
  logic [4:0]        tpb;

  fbg_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .div_eff(div_eff), .frac(frac), .rate_x2(rate_x2),
    .rate_x4(rate_x4), .clk_off(clk_off)
  );

  fbg_period #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .clk_off(clk_off),
    .div_eff(div_eff), .frac(frac), .hit(tick_hit),
    .stretch(stretch), .tick(tick)
  );

  assign tpb = ticks_per_bit(rate_x2, rate_x4);

  fbg_bitdiv #(.SUB_W(4)) u_bitdiv (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .clk_off(clk_off),
    .hit(tick_hit), .tpb(tpb), .bit_tick(bit_tick)
  );

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              tick,
  input logic              bit_tick,
  input logic              clk_off,
  input logic              stretch,
  input logic [FRAC_W-1:0] frac,
  input logic [DIV_W-1:0]  div_eff
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!tick && !bit_tick)); // R7

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off |=> (!tick && !bit_tick)); // R6

  AST_BIT_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> tick); // R5

  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R5

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_eff > DIV_ONE)) |=> !tick); // R3

  AST_STRETCH_NEEDS_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> (frac != '0)); // R3

endmodule

bind frac_baud_gen fbg_checker #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick),
  .bit_tick(bit_tick), .clk_off(clk_off), .stretch(stretch),
  .frac(frac), .div_eff(div_eff)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       tick, bit_tick;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick(tick), .bit_tick(bit_tick)
  );

  // Cycle after the restart edge at which tick n appears.
  function automatic longint tick_pos(input int n, input int d, input int f);
    return longint'(n) * longint'(d) + longint'(((n - 1) * f) / 16);
  endfunction

  // Ticks per bit: mode bit 0 doubles the rate, mode bit 1 quadruples it and wins.
  function automatic int bit_len(input int m);
    if (m[1])      return 4;
    else if (m[0]) return 8;
    else           return 16;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d: got 0x%02h expected 0x%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Program divisor, fraction and mode, then compare the whole tick train.
  task automatic run(input string req, input int d, input int f, input int m, input int cycles);
    int  deff, n, tp;
    bit  bad;
    logic et, eb;
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
    wr(2'd2, {2'b00, m[1], m[0], f[3:0]});
    deff = (d == 0) ? 1 : d;
    tp   = bit_len(m);
    n    = 1;
    bad  = 1'b0;
    if (tick !== 1'b0 || bit_tick !== 1'b0) begin
      bad = 1'b1;
      $display("FAIL %s (R7) after write: tick=%b bit=%b expected 0 0", req, tick, bit_tick);
    end
    for (int c = 1; c <= cycles; c++) begin
      @(posedge clk);
      @(negedge clk);
      et = (longint'(c) == tick_pos(n, deff, f));
      eb = et && ((n % tp) == 0);
      if ((tick !== et || bit_tick !== eb) && !bad) begin
        bad = 1'b1;
        $display("FAIL %s d=%0d f=%0d m=%0d cycle %0d: tick=%b bit=%b expected tick=%b bit=%b",
                 req, d, f, m, c, tick, bit_tick, et, eb);
      end
      if (et) n++;
    end
    checks++;
    if (bad) fails++;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R1 tick in reset", tick, 1'b0);
    chk_bit("R1 bit_tick in reset", bit_tick, 1'b0);
    rst_n = 1'b1;
    chk_rd("R1", 2'd0, 8'h01);
    chk_rd("R1", 2'd1, 8'h00);
    chk_rd("R1", 2'd2, 8'h00);
    chk_rd("R1", 2'd3, 8'h00);

    // R2 register storage and the unstored configuration bit 7
    wr(2'd1, 8'hA5);
    chk_rd("R2", 2'd1, 8'hA5);
    wr(2'd0, 8'h3C);
    chk_rd("R2", 2'd0, 8'h3C);
    wr(2'd2, 8'hFF);
    chk_rd("R2", 2'd2, 8'h7F);

    // R3 fractional spread
    run("R3", 5, 3, 0, 200);
    run("R3", 7, 15, 0, 300);
    run("R3", 3, 0, 0, 100);
    run("R3", 2, 8, 0, 120);

    // R4 zero divisor
    run("R4", 0, 0, 0, 40);
    chk_rd("R4", 2'd0, 8'h00);
    run("R4", 0, 9, 1, 80);

    // R5 rate modes
    run("R5", 2, 5, 1, 120);
    run("R5", 2, 5, 2, 120);
    run("R5", 2, 5, 3, 120);

    // R6 clock disable
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h40);
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (tick !== 1'b0 || bit_tick !== 1'b0) seen = 1'b1;
      end
      chk_bit("R6 outputs while disabled", seen, 1'b0);
    end
    run("R6 re-enable", 4, 0, 0, 100);

    // R7 write while ticking every cycle
    run("R7", 1, 0, 0, 10);
    wr(2'd2, 8'h00);
    chk_bit("R7 tick after write", tick, 1'b0);
    @(negedge clk);
    chk_bit("R7 first tick after restart", tick, 1'b1);

    // R8 extremes
    run("R8", 1, 0, 2, 40);
    run("R8", 16'hFFFF, 15, 0, 65540);

    // Random mix of divisors, fractions and modes
    void'($urandom(32'd24681));
    for (int i = 0; i < 16; i++) begin
      int d, f, m;
      d = 1 + int'($urandom % 24);
      f = int'($urandom % 16);
      m = int'($urandom % 4);
      run("R3/R5 random", d, f, m, 20 * d + 64);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule